// File: doc/BRIEF.md
# AXI4 Burst Memory Slave

This block is an AXI4 slave in front of an on-chip array of 64-bit words. It takes INCR and WRAP bursts of whole words, up to a small number of beats each. Burst types it does not handle, and transfers that are not whole 64-bit words, get an error response and leave the array untouched.

Write beats are gathered into a local buffer. The array is updated only on the cycle in which the write response handshakes, so a write becomes visible all at once. Only one write can be open at a time. A read copies its whole burst out of the array in the cycle its address is accepted, then returns the beats one per handshake. A side port lets another agent merge a single word into the array under a bit mask.

Top module: `axi_burst_mem`

## Requirements
- R1: While reset (`rst_n` low, synchronous) is applied and in the cycle after it, `rvalid`, `bvalid` and `wready` are low, and `awready` and `arready` are high.
- R2: A request is legal only when all of these hold: size code is 3 (8-byte beats), the length field is below MAX_BEATS, and the burst code is INCR (1), or WRAP (2) with a beat count of 2, 4 or 8. An illegal write still takes its len+1 data beats, answers with response 2'b10 and changes no word. An illegal read returns len+1 beats of zero data with response 2'b10. Legal transfers answer 2'b00.
- R3: In an INCR burst, beat k uses word ((addr >> 3) + k) mod MEM_WORDS.
- R4: In a WRAP burst of n beats, the words lie in the n-word window aligned to a multiple of n that holds the start word. Beat k uses word low + ((start - low + k) mod n).
- R5: The word index is addr[IDX_W+2:3]. Address bits above it are ignored, so addresses alias modulo MEM_WORDS words.
- R6: After an AW handshake, `awready` stays low until the B handshake. `wready` is high from the next cycle until the len+1-th data beat is taken, and is low otherwise.
- R7: A write changes the array only in the cycle of its B handshake. Reads accepted before that see the old words. `bvalid` is held until `bready`, and `bid` equals the write's `awid`.
- R8: Read beats come out in order, with `rid` equal to `arid` and `rlast` only on the final beat. While `rready` is low, `rvalid`, `rdata` and `rlast` hold steady. `arready` is low from the AR handshake until the final beat handshakes.
- R9: Read data is the array content as it stood when the AR handshake occurred. Later direct writes do not change beats that are still pending.
- R10: A direct write sets word `dw_idx` to (old & ~`dw_mask`) | (`dw_data` & `dw_mask`).
- R11: When a direct write and a burst commit hit the same word in the same cycle, the mask merge is applied on top of the committed value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| awvalid | input | 1 | Write address valid |
| awready | output | 1 | Write address ready |
| awid | input | ID_W | Write ID |
| awaddr | input | ADDR_W | Write byte address |
| awlen | input | 8 | Write beats minus one |
| awsize | input | 3 | Write beat size code |
| awburst | input | 2 | Write burst type |
| wvalid | input | 1 | Write data valid |
| wready | output | 1 | Write data ready |
| wdata | input | 64 | Write data |
| bvalid | output | 1 | Write response valid |
| bready | input | 1 | Write response ready |
| bid | output | ID_W | Write response ID |
| bresp | output | 2 | Write response code |
| arvalid | input | 1 | Read address valid |
| arready | output | 1 | Read address ready |
| arid | input | ID_W | Read ID |
| araddr | input | ADDR_W | Read byte address |
| arlen | input | 8 | Read beats minus one |
| arsize | input | 3 | Read beat size code |
| arburst | input | 2 | Read burst type |
| rvalid | output | 1 | Read data valid |
| rready | input | 1 | Read data ready |
| rdata | output | 64 | Read data |
| rid | output | ID_W | Read ID |
| rlast | output | 1 | Final read beat |
| rresp | output | 2 | Read response code |
| dw_en | input | 1 | Direct word write enable |
| dw_idx | input | IDX_W | Direct write word index |
| dw_data | input | 64 | Direct write data |
| dw_mask | input | 64 | Direct write bit mask |

## Verification
The burst commit at the B handshake and a masked direct write can land on the same word in the same cycle. The bench provokes this by raising `bready` and `dw_en`, aimed at the word the pending burst covers, at the same falling edge. It then reads the word back over AXI and compares it with a model value: the committed data first, then the mask merge on top. A second overlap is also covered. A direct write is issued while a read burst is still being returned, and the beats must show the snapshot taken at AR time.

// File: rtl/axi_burst_mem_pkg.sv
package axi_burst_mem_pkg;
  localparam logic [1:0] BT_FIXED   = 2'd0;
  localparam logic [1:0] BT_INCR    = 2'd1;
  localparam logic [1:0] BT_WRAP    = 2'd2;
  localparam logic [1:0] RSP_OKAY   = 2'b00;
  localparam logic [1:0] RSP_SLVERR = 2'b10;
  localparam logic [2:0] WORD_SIZE  = 3'd3;

  typedef enum logic [1:0] {PH_IDLE, PH_DATA, PH_RESP} phase_e;

  // Legal: whole-word beats, length within the buffer, INCR or power-of-two WRAP
  function automatic logic burst_legal(input logic [1:0] burst, input logic [2:0] size,
                                       input logic [7:0] len, input logic [31:0] max_beats);
    logic pow2;
    pow2 = (len != 8'd0) && (((len + 8'd1) & len) == 8'd0);
    return (size == WORD_SIZE) && ({24'd0, len} < max_beats) &&
           ((burst == BT_INCR) || ((burst == BT_WRAP) && pow2));
  endfunction

  // Word used by beat k; words must be a power of two
  function automatic logic [31:0] beat_word(input logic [31:0] start, input logic [31:0] k,
                                            input logic [1:0] burst, input logic [7:0] len,
                                            input logic [31:0] words);
    logic [31:0] span;
    logic [31:0] lo;
    span = {24'd0, len};
    if (burst == BT_WRAP) begin
      lo = start & ~span;
      return (lo | ((start + k) & span)) & (words - 32'd1);
    end
    return (start + k) & (words - 32'd1);
  endfunction
endpackage

// File: rtl/abm_mem_array.sv
module abm_mem_array
  import axi_burst_mem_pkg::*;
#(
  parameter int MEM_WORDS = 256,
  parameter int MAX_BEATS = 8,
  parameter int IDX_W     = $clog2(MEM_WORDS)
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            commit_en,
  input  logic [IDX_W-1:0]                cm_start,
  input  logic [7:0]                      cm_len,
  input  logic [1:0]                      cm_burst,
  input  logic [MAX_BEATS-1:0][63:0]      cm_data,
  input  logic                            dw_en,
  input  logic [IDX_W-1:0]                dw_idx,
  input  logic [63:0]                     dw_data,
  input  logic [63:0]                     dw_mask,
  input  logic [IDX_W-1:0]                rd_start,
  input  logic [7:0]                      rd_len,
  input  logic [1:0]                      rd_burst,
  output logic [MAX_BEATS-1:0][63:0]      rd_words
);
  localparam logic [31:0] WORDS32 = 32'(MEM_WORDS);

  logic [63:0] mem [MEM_WORDS];
  logic [IDX_W-1:0] cm_idx [MAX_BEATS];
  logic [MAX_BEATS-1:0] cm_act;
  logic [IDX_W-1:0] rd_idx [MAX_BEATS];
  logic [63:0] dw_base;
  logic [63:0] dw_merged;

  always_comb begin
    for (int k = 0; k < MAX_BEATS; k++) begin
      logic [31:0] t;
      logic [31:0] u;
      t = beat_word({{(32-IDX_W){1'b0}}, cm_start}, 32'(k), cm_burst, cm_len, WORDS32);
      u = beat_word({{(32-IDX_W){1'b0}}, rd_start}, 32'(k), rd_burst, rd_len, WORDS32);
      cm_idx[k] = t[IDX_W-1:0];
      rd_idx[k] = u[IDX_W-1:0];
      cm_act[k] = commit_en && (32'(k) <= {24'd0, cm_len});
    end
  end

  // Word value after this cycle's commit, the base for the masked merge
  always_comb begin
    dw_base = mem[dw_idx];
    for (int k = 0; k < MAX_BEATS; k++)
      if (cm_act[k] && (cm_idx[k] == dw_idx)) dw_base = cm_data[k];
  end

  assign dw_merged = (dw_base & ~dw_mask) | (dw_data & dw_mask);

  always_ff @(posedge clk) begin
    for (int k = 0; k < MAX_BEATS; k++)
      if (cm_act[k]) mem[cm_idx[k]] <= cm_data[k];
    if (dw_en) mem[dw_idx] <= dw_merged;
  end

  always_comb
    for (int k = 0; k < MAX_BEATS; k++) rd_words[k] = mem[rd_idx[k]];

  p_merge_r10: assert property (@(posedge clk) disable iff (!rst_n)
    dw_en |=> mem[$past(dw_idx)] ==
              (($past(dw_base) & ~$past(dw_mask)) | ($past(dw_data) & $past(dw_mask))));

  p_commit_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_en && !dw_en) |=> mem[$past(cm_idx[0])] == $past(cm_data[0]));
endmodule

// File: rtl/abm_write_ctrl.sv
module abm_write_ctrl
  import axi_burst_mem_pkg::*;
#(
  parameter int ID_W      = 4,
  parameter int ADDR_W    = 32,
  parameter int IDX_W     = 8,
  parameter int MAX_BEATS = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       awvalid,
  output logic                       awready,
  input  logic [ID_W-1:0]            awid,
  input  logic [ADDR_W-1:0]          awaddr,
  input  logic [7:0]                 awlen,
  input  logic [2:0]                 awsize,
  input  logic [1:0]                 awburst,
  input  logic                       wvalid,
  output logic                       wready,
  input  logic [63:0]                wdata,
  output logic                       bvalid,
  input  logic                       bready,
  output logic [ID_W-1:0]            bid,
  output logic [1:0]                 bresp,
  output logic                       commit_en,
  output logic [IDX_W-1:0]           cm_start,
  output logic [7:0]                 cm_len,
  output logic [1:0]                 cm_burst,
  output logic [MAX_BEATS-1:0][63:0] cm_data
);
  localparam int OFF_W = $clog2(MAX_BEATS);

  phase_e st;
  logic aw_hs, w_hs, b_hs, final_beat;
  logic [7:0] woff, wlen;
  logic werr;
  logic [1:0] wburst;
  logic [IDX_W-1:0] wstart;
  logic [ID_W-1:0] wid;
  logic [MAX_BEATS-1:0][63:0] wbuf;
  logic unused_aw_bits;

  assign unused_aw_bits = ^{awaddr[2:0], awaddr[ADDR_W-1:IDX_W+3]};

  assign awready    = (st == PH_IDLE);
  assign wready     = (st == PH_DATA);
  assign bvalid     = (st == PH_RESP);
  assign aw_hs      = awvalid && awready;
  assign w_hs       = wvalid && wready;
  assign b_hs       = bvalid && bready;
  assign final_beat = w_hs && (woff == wlen);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= PH_IDLE;
      woff   <= '0;
      wlen   <= '0;
      werr   <= 1'b0;
      wburst <= BT_INCR;
      wstart <= '0;
      wid    <= '0;
    end else begin
      unique case (st)
        PH_IDLE: if (aw_hs) begin
          st     <= PH_DATA;
          woff   <= '0;
          wlen   <= awlen;
          werr   <= !burst_legal(awburst, awsize, awlen, 32'(MAX_BEATS));
          wburst <= awburst;
          wstart <= awaddr[IDX_W+2:3];
          wid    <= awid;
        end
        PH_DATA: if (final_beat) st <= PH_RESP;
                 else if (w_hs)  woff <= woff + 8'd1;
        PH_RESP: if (b_hs) st <= PH_IDLE;
        default: st <= PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk)
    if (w_hs && !werr) wbuf[woff[OFF_W-1:0]] <= wdata;

  assign bid       = wid;
  assign bresp     = werr ? RSP_SLVERR : RSP_OKAY;
  assign commit_en = b_hs && !werr;
  assign cm_start  = wstart;
  assign cm_len    = wlen;
  assign cm_burst  = wburst;
  assign cm_data   = wbuf;

  p_aw_block_r6: assert property (@(posedge clk) disable iff (!rst_n)
    aw_hs |=> !awready && wready);

  p_aw_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!awready && !b_hs) |=> !awready);

  p_b_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bvalid && !bready) |=> bvalid && $stable(bid) && $stable(bresp));

  p_no_w_in_resp_r6: assert property (@(posedge clk) disable iff (!rst_n)
    final_beat |=> !wready && bvalid);
endmodule

// File: rtl/abm_read_ctrl.sv
module abm_read_ctrl
  import axi_burst_mem_pkg::*;
#(
  parameter int ID_W      = 4,
  parameter int ADDR_W    = 32,
  parameter int IDX_W     = 8,
  parameter int MAX_BEATS = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       arvalid,
  output logic                       arready,
  input  logic [ID_W-1:0]            arid,
  input  logic [ADDR_W-1:0]          araddr,
  input  logic [7:0]                 arlen,
  input  logic [2:0]                 arsize,
  input  logic [1:0]                 arburst,
  output logic                       rvalid,
  input  logic                       rready,
  output logic [63:0]                rdata,
  output logic [ID_W-1:0]            rid,
  output logic                       rlast,
  output logic [1:0]                 rresp,
  output logic [IDX_W-1:0]           rd_start,
  output logic [7:0]                 rd_len,
  output logic [1:0]                 rd_burst,
  input  logic [MAX_BEATS-1:0][63:0] rd_words
);
  localparam int OFF_W = $clog2(MAX_BEATS);

  phase_e st;
  logic ar_hs, r_hs;
  logic [7:0] roff, rlen;
  logic rerr;
  logic [ID_W-1:0] rid_q;
  logic [MAX_BEATS-1:0][63:0] rbuf;
  logic unused_ar_bits;

  assign unused_ar_bits = ^{araddr[2:0], araddr[ADDR_W-1:IDX_W+3]};

  assign arready  = (st == PH_IDLE);
  assign rvalid   = (st == PH_DATA);
  assign ar_hs    = arvalid && arready;
  assign r_hs     = rvalid && rready;
  assign rd_start = araddr[IDX_W+2:3];
  assign rd_len   = arlen;
  assign rd_burst = arburst;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= PH_IDLE;
      roff  <= '0;
      rlen  <= '0;
      rerr  <= 1'b0;
      rid_q <= '0;
    end else begin
      unique case (st)
        PH_IDLE: if (ar_hs) begin
          st    <= PH_DATA;
          roff  <= '0;
          rlen  <= arlen;
          rerr  <= !burst_legal(arburst, arsize, arlen, 32'(MAX_BEATS));
          rid_q <= arid;
        end
        PH_DATA: if (r_hs) begin
          if (roff == rlen) st <= PH_IDLE;
          else              roff <= roff + 8'd1;
        end
        default: st <= PH_IDLE;
      endcase
    end
  end

  // Snapshot of the whole burst at address acceptance
  always_ff @(posedge clk)
    if (ar_hs) rbuf <= rd_words;

  assign rdata = rerr ? 64'd0 : rbuf[roff[OFF_W-1:0]];
  assign rid   = rid_q;
  assign rlast = rvalid && (roff == rlen);
  assign rresp = rerr ? RSP_SLVERR : RSP_OKAY;

  p_r_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rvalid && !rready) |=> rvalid && $stable(rdata) && $stable(rlast) && $stable(rid));

  p_ar_block_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ar_hs |=> !arready && rvalid);

  p_last_frees_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (r_hs && rlast) |=> arready && !rvalid);
endmodule

// File: rtl/axi_burst_mem.sv
module axi_burst_mem
  import axi_burst_mem_pkg::*;
#(
  parameter int ID_W      = 4,
  parameter int ADDR_W    = 32,
  parameter int MEM_WORDS = 256,
  parameter int MAX_BEATS = 8,
  parameter int IDX_W     = $clog2(MEM_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              awvalid,
  output logic              awready,
  input  logic [ID_W-1:0]   awid,
  input  logic [ADDR_W-1:0] awaddr,
  input  logic [7:0]        awlen,
  input  logic [2:0]        awsize,
  input  logic [1:0]        awburst,
  input  logic              wvalid,
  output logic              wready,
  input  logic [63:0]       wdata,
  output logic              bvalid,
  input  logic              bready,
  output logic [ID_W-1:0]   bid,
  output logic [1:0]        bresp,
  input  logic              arvalid,
  output logic              arready,
  input  logic [ID_W-1:0]   arid,
  input  logic [ADDR_W-1:0] araddr,
  input  logic [7:0]        arlen,
  input  logic [2:0]        arsize,
  input  logic [1:0]        arburst,
  output logic              rvalid,
  input  logic              rready,
  output logic [63:0]       rdata,
  output logic [ID_W-1:0]   rid,
  output logic              rlast,
  output logic [1:0]        rresp,
  input  logic              dw_en,
  input  logic [IDX_W-1:0]  dw_idx,
  input  logic [63:0]       dw_data,
  input  logic [63:0]       dw_mask
);
  logic                       commit_en;
  logic [IDX_W-1:0]           cm_start, rd_start;
  logic [7:0]                 cm_len, rd_len;
  logic [1:0]                 cm_burst, rd_burst;
  logic [MAX_BEATS-1:0][63:0] cm_data, rd_words;

  abm_write_ctrl #(.ID_W(ID_W), .ADDR_W(ADDR_W), .IDX_W(IDX_W), .MAX_BEATS(MAX_BEATS)) u_wr (
    .clk(clk), .rst_n(rst_n),
    .awvalid(awvalid), .awready(awready), .awid(awid), .awaddr(awaddr),
    .awlen(awlen), .awsize(awsize), .awburst(awburst),
    .wvalid(wvalid), .wready(wready), .wdata(wdata),
    .bvalid(bvalid), .bready(bready), .bid(bid), .bresp(bresp),
    .commit_en(commit_en), .cm_start(cm_start), .cm_len(cm_len),
    .cm_burst(cm_burst), .cm_data(cm_data));

  abm_read_ctrl #(.ID_W(ID_W), .ADDR_W(ADDR_W), .IDX_W(IDX_W), .MAX_BEATS(MAX_BEATS)) u_rd (
    .clk(clk), .rst_n(rst_n),
    .arvalid(arvalid), .arready(arready), .arid(arid), .araddr(araddr),
    .arlen(arlen), .arsize(arsize), .arburst(arburst),
    .rvalid(rvalid), .rready(rready), .rdata(rdata), .rid(rid),
    .rlast(rlast), .rresp(rresp),
    .rd_start(rd_start), .rd_len(rd_len), .rd_burst(rd_burst), .rd_words(rd_words));

  abm_mem_array #(.MEM_WORDS(MEM_WORDS), .MAX_BEATS(MAX_BEATS), .IDX_W(IDX_W)) u_mem (
    .clk(clk), .rst_n(rst_n),
    .commit_en(commit_en), .cm_start(cm_start), .cm_len(cm_len),
    .cm_burst(cm_burst), .cm_data(cm_data),
    .dw_en(dw_en), .dw_idx(dw_idx), .dw_data(dw_data), .dw_mask(dw_mask),
    .rd_start(rd_start), .rd_len(rd_len), .rd_burst(rd_burst), .rd_words(rd_words));

  p_reset_idle_r1: assert property (@(posedge clk)
    !rst_n |=> !rvalid && !bvalid && !wready && awready && arready);
endmodule

// File: tb/axi_burst_mem_tb_top.sv
module axi_burst_mem_tb_top;
  localparam int MW = 256;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        awvalid = 0, wvalid = 0, bready = 0, arvalid = 0, rready = 0, dw_en = 0;
  logic [3:0]  awid = 0, arid = 0;
  logic [31:0] awaddr = 0, araddr = 0;
  logic [7:0]  awlen = 0, arlen = 0;
  logic [2:0]  awsize = 3, arsize = 3;
  logic [1:0]  awburst = 1, arburst = 1;
  logic [63:0] wdata = 0, dw_data = 0, dw_mask = 0;
  logic [7:0]  dw_idx = 0;
  logic        awready, wready, bvalid, arready, rvalid, rlast;
  logic [3:0]  bid, rid;
  logic [1:0]  bresp, rresp;
  logic [63:0] rdata;

  axi_burst_mem dut_i (
    .clk(clk), .rst_n(rst_n),
    .awvalid(awvalid), .awready(awready), .awid(awid), .awaddr(awaddr),
    .awlen(awlen), .awsize(awsize), .awburst(awburst),
    .wvalid(wvalid), .wready(wready), .wdata(wdata),
    .bvalid(bvalid), .bready(bready), .bid(bid), .bresp(bresp),
    .arvalid(arvalid), .arready(arready), .arid(arid), .araddr(araddr),
    .arlen(arlen), .arsize(arsize), .arburst(arburst),
    .rvalid(rvalid), .rready(rready), .rdata(rdata), .rid(rid),
    .rlast(rlast), .rresp(rresp),
    .dw_en(dw_en), .dw_idx(dw_idx), .dw_data(dw_data), .dw_mask(dw_mask));

  typedef struct {
    logic [63:0] data;
    logic [3:0]  id;
    logic        last;
    logic [1:0]  resp;
    string       tag;
  } exp_t;

  exp_t        sb[$];
  logic [63:0] model [MW];
  int          n_checks = 0, n_errors = 0;
  bit          finished = 0;

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic int widx(int base, int k, int burst, int len);
    int n, low;
    n = len + 1;
    if (burst == 2) begin
      low = base - (base % n);
      return (low + ((base - low + k) % n)) % MW;
    end
    return (base + k) % MW;
  endfunction

  // rready pattern: stalls one cycle in four, changed away from the sampling edge
  int rcnt = 0;
  always @(posedge clk) begin
    #2;
    rcnt++;
    rready = (rcnt % 4) != 3;
  end

  // Monitor: pops expected beats and compares; also checks stall stability (R8)
  logic        stalled = 0;
  logic [63:0] st_data;
  always @(negedge clk) begin
    if (rst_n && rvalid) begin
      if (stalled) check("R8 data stable during stall", rdata, st_data);
      if (rready) begin
        if (sb.size() == 0) check("R8 unexpected beat", 64'd1, 64'd0);
        else begin
          exp_t e;
          e = sb.pop_front();
          check({e.tag, " data"}, rdata, e.data);
          check("R8 rid", {60'd0, rid}, {60'd0, e.id});
          check("R8 rlast", {63'd0, rlast}, {63'd0, e.last});
          check("R2 rresp", {62'd0, rresp}, {62'd0, e.resp});
        end
        stalled = 0;
      end else begin
        stalled = 1;
        st_data = rdata;
      end
    end else stalled = 0;
  end

  task automatic direct(int idx, logic [63:0] d, logic [63:0] m);
    @(negedge clk);
    dw_en = 1; dw_idx = 8'(idx); dw_data = d; dw_mask = m;
    model[idx] = (model[idx] & ~m) | (d & m);
    @(negedge clk);
    dw_en = 0;
  endtask

  // AR phase only; expected beats are pushed from the model at acceptance
  task automatic rd_issue(int id, logic [31:0] addr, int len, int burst, int size, bit err, string tag);
    @(negedge clk);
    arvalid = 1; arid = 4'(id); araddr = addr; arlen = 8'(len);
    arburst = 2'(burst); arsize = 3'(size);
    while (!arready) @(negedge clk);
    for (int k = 0; k <= len; k++) begin
      exp_t e;
      e.data = err ? 64'd0 : model[widx(int'(addr[10:3]), k, burst, len)];
      e.id = 4'(id); e.last = (k == len); e.resp = err ? 2'b10 : 2'b00; e.tag = tag;
      sb.push_back(e);
    end
    @(negedge clk);
    arvalid = 0;
    check("R8 arready low during burst", {63'd0, arready}, 64'd0);
  endtask

  task automatic rd_drain();
    while (sb.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  int          pw_base, pw_len, pw_burst, pw_id;
  logic [63:0] pw_data [8];

  task automatic wr_data(int id, logic [31:0] addr, int len, int burst, int size, logic [63:0] pat);
    @(negedge clk);
    awvalid = 1; awid = 4'(id); awaddr = addr; awlen = 8'(len);
    awburst = 2'(burst); awsize = 3'(size);
    while (!awready) @(negedge clk);
    @(negedge clk);
    awvalid = 0;
    check("R6 awready low after AW", {63'd0, awready}, 64'd0);
    check("R6 wready high after AW", {63'd0, wready}, 64'd1);
    pw_base = int'(addr[10:3]); pw_len = len; pw_burst = burst; pw_id = id;
    for (int k = 0; k <= len; k++) begin
      wvalid = 1; wdata = pat + 64'(k);
      if (k < 8) pw_data[k] = wdata;
      while (!wready) @(negedge clk);
      @(negedge clk);
    end
    wvalid = 0;
    check("R6 wready low after final beat", {63'd0, wready}, 64'd0);
    check("R6 awready low while response pending", {63'd0, awready}, 64'd0);
  endtask

  task automatic wr_resp(bit err, bit with_dw, int di, logic [63:0] dd, logic [63:0] dm);
    bready = 1;
    while (!bvalid) @(negedge clk);
    check("R7 bid", {60'd0, bid}, 64'(pw_id));
    check("R2 bresp", {62'd0, bresp}, err ? 64'd2 : 64'd0);
    if (!err)
      for (int k = 0; k <= pw_len; k++) model[widx(pw_base, k, pw_burst, pw_len)] = pw_data[k];
    if (with_dw) begin
      dw_en = 1; dw_idx = 8'(di); dw_data = dd; dw_mask = dm;
      model[di] = (model[di] & ~dm) | (dd & dm);
    end
    @(negedge clk);
    bready = 0; dw_en = 0;
    check("R6 awready back after B", {63'd0, awready}, 64'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 rvalid in reset", {63'd0, rvalid}, 64'd0);
    check("R1 bvalid in reset", {63'd0, bvalid}, 64'd0);
    check("R1 wready in reset", {63'd0, wready}, 64'd0);
    check("R1 awready in reset", {63'd0, awready}, 64'd1);
    check("R1 arready in reset", {63'd0, arready}, 64'd1);
    rst_n = 1;

    // R10: fill the array through the direct port, then a partial merge
    for (int i = 0; i < MW; i++) begin
      model[i] = 64'd0;
      direct(i, {32'hC0DE_0000 + 32'(i), 32'(i) * 32'h0101_0101}, '1);
    end
    direct(5, 64'hFFFF_FFFF_FFFF_FFFF, 64'h00FF_FF00_0000_F00F);
    rd_issue(1, 32'h28, 0, 1, 3, 0, "R10 masked merge");
    rd_drain();

    // R3: INCR four beats
    wr_data(2, 32'h100, 3, 1, 3, 64'h1111_0000_0000_0000);
    wr_resp(0, 0, 0, 0, 0);
    rd_issue(3, 32'h100, 3, 1, 3, 0, "R3 INCR readback");
    rd_drain();

    // R4: WRAP write from word 45 (4 beats), WRAP read of 8 from word 42
    wr_data(4, 32'h168, 3, 2, 3, 64'h2222_0000_0000_0000);
    wr_resp(0, 0, 0, 0, 0);
    rd_issue(5, 32'h150, 7, 2, 3, 0, "R4 WRAP eight beats");
    rd_drain();
    rd_issue(6, 32'h160, 3, 1, 3, 0, "R4 WRAP placement");
    rd_drain();

    // R5: high address bits alias; INCR crossing the top of the array
    wr_data(7, 32'h1234_0040, 1, 1, 3, 64'h3333_0000_0000_0000);
    wr_resp(0, 0, 0, 0, 0);
    rd_issue(8, 32'h40, 1, 1, 3, 0, "R5 alias readback");
    rd_drain();
    wr_data(9, 32'h7F0, 3, 1, 3, 64'h4444_0000_0000_0000);
    wr_resp(0, 0, 0, 0, 0);
    rd_issue(10, 32'hFFFF_F7F0, 3, 1, 3, 0, "R5 modulo wrap-around");
    rd_drain();

    // R2: illegal requests
    wr_data(11, 32'h1E0, 1, 0, 3, 64'h5555_0000_0000_0000);
    wr_resp(1, 0, 0, 0, 0);
    wr_data(12, 32'h1E0, 0, 1, 2, 64'h5656_0000_0000_0000);
    wr_resp(1, 0, 0, 0, 0);
    rd_issue(13, 32'h1E0, 1, 1, 3, 0, "R2 unchanged after error write");
    rd_drain();
    rd_issue(14, 32'h1E0, 2, 0, 3, 1, "R2 FIXED read");
    rd_drain();
    rd_issue(15, 32'h1E0, 2, 2, 3, 1, "R2 WRAP of three");
    rd_drain();
    rd_issue(1, 32'h1E0, 3, 3, 3, 1, "R2 reserved burst");
    rd_drain();

    // R7: read before the B handshake sees old data
    wr_data(2, 32'h230, 1, 1, 3, 64'h6666_0000_0000_0000);
    rd_issue(3, 32'h230, 1, 1, 3, 0, "R7 old data before B");
    rd_drain();
    check("R7 bvalid held without bready", {63'd0, bvalid}, 64'd1);
    wr_resp(0, 0, 0, 0, 0);
    rd_issue(4, 32'h230, 1, 1, 3, 0, "R7 new data after B");
    rd_drain();

    // R11: commit and direct merge on the same word in one cycle
    wr_data(5, 32'h280, 1, 1, 3, 64'h7777_0000_0000_0000);
    wr_resp(0, 1, 80, 64'hAAAA_AAAA_BBBB_BBBB, 64'h0000_0000_FFFF_0000);
    rd_issue(6, 32'h280, 1, 1, 3, 0, "R11 merge over commit");
    rd_drain();

    // R9: direct write during a pending read burst does not alter it
    rd_issue(7, 32'h300, 7, 1, 3, 0, "R9 snapshot");
    direct(101, 64'hDEAD_BEEF_0000_0001, '1);
    direct(103, 64'hDEAD_BEEF_0000_0002, '1);
    rd_drain();
    rd_issue(8, 32'h328, 0, 1, 3, 0, "R10 direct write visible");
    rd_drain();

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end
endmodule